// File: doc/BRIEF.md
# E1 Sa-Bit Multiframe Capture Buffers

This block collects the five national spare bits (Sa4 to Sa8) from time slot 0 of the E1 frames that carry no frame alignment word. It gathers eight of each across one 16-frame multiframe in hidden staging shift registers. At the next multiframe boundary it copies all five staged bytes into processor-readable registers in one step.

A single-cycle interrupt pulse marks each refresh. Software then has one full multiframe period (2 ms at line rate) to read any register before its content can change. An upstream aligner supplies the bit position within the frame, the frame number within the multiframe and a strobe at the start of each multiframe. This block does no alignment and no CRC work.

The serial input is a valid-qualified stream with no ready signal. The line cannot be stalled, so the block accepts every bit offered with `rx_vld_i` high and never applies back-pressure. The read port is a plain combinational address/data pair with no handshake.

Top module: `e1_sa_capture`

## Requirements
- R1: A bit is captured only when `rx_vld_i` is high, `frm_num_i[0]` is 1 (odd frame, no alignment word) and `bit_pos_i` is 3 to 7 (zero-based; positions 4 to 8 counting the first bit as 1). Position 3 feeds Sa4 and position 7 feeds Sa8. Even-frame bits and bits at other positions have no effect.
- R2: In each register, the bit from the first odd frame of the multiframe lands in bit 7 and the bit from the eighth lands in bit 0. `sa_regs_o` packs Sa4 in bits [7:0], Sa5 in [15:8], and so on up to Sa8 in [39:32].
- R3: The readable registers change only at a multiframe boundary, and all five take their new values on the same clock edge.
- R4: After a refresh, the register contents stay unchanged for the whole following multiframe while new bits are staged.
- R5: `mf_irq_o` is a one-cycle pulse. It is high in the cycle after `mf_start_i` is sampled high, which is the same cycle in which the registers show the new values.
- R6: A refresh (with its interrupt) occurs only if exactly eight odd-frame Sa8 bits were captured since the previous `mf_start_i`. Otherwise the staged bits are discarded, no interrupt is raised and the registers keep their old content.
- R7: Reset clears the registers to 0x00 and the interrupt to 0. The first `mf_start_i` after reset only arms the block and raises no interrupt. Bits seen before that first strobe are not counted.
- R8: `rd_data_o` is combinational. `rd_addr_i` 0 to 4 selects the Sa4 to Sa8 register, and addresses 5 to 7 return zero.
- R9: Cycles with `rx_vld_i` low leave staging unchanged, whatever `rx_bit_i` and the position inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_vld_i | input | 1 | Serial bit valid (no ready; always accepted) |
| rx_bit_i | input | 1 | Serial receive data bit |
| bit_pos_i | input | 8 | Bit index within the frame, 0 to 255 |
| frm_num_i | input | 4 | Frame number within the multiframe, 0 to 15 |
| mf_start_i | input | 1 | Strobe with the first bit of frame 0 |
| rd_addr_i | input | 3 | Register select for the read port |
| rd_data_o | output | 8 | Selected register value |
| sa_regs_o | output | 40 | All five readable registers, Sa4 lowest |
| mf_irq_o | output | 1 | Refresh interrupt pulse |

## Verification
A fault in the position or frame-parity decode, or in the shift direction, shows as wrong register bytes at the very next refresh, one multiframe after the bad bit enters staging. A wrong odd-frame counter or arming flag shows as a missing or extra interrupt at the first boundary that follows a short multiframe, or at the first strobe after reset. A stuck transfer enable shows in the middle of a multiframe as register contents that drift away from the last refreshed values.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int SA_NUM         = 5;
  localparam int SA_W           = 8;
  localparam int SA_FIRST       = 3;
  localparam int ODD_PER_MF     = 8;
  localparam int FRAMES_PER_MF  = 16;
  localparam int BITS_PER_FRAME = 256;
  localparam int IDX_W          = $clog2(SA_NUM + 3);
  localparam int POS_W          = $clog2(BITS_PER_FRAME);
  localparam int FRM_W          = $clog2(FRAMES_PER_MF);

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             last;
  } sa_tap_t;
endpackage

// File: rtl/e1_sa_slot_decode.sv
module e1_sa_slot_decode
  import e1_sa_pkg::*;
#(
  parameter int N_SA  = SA_NUM,
  parameter int BASE  = SA_FIRST,
  parameter int PW    = POS_W,
  parameter int FW    = FRM_W,
  parameter int NFRM  = FRAMES_PER_MF
) (
  input  logic          vld_i,
  input  logic [PW-1:0] pos_i,
  input  logic [FW-1:0] frm_i,
  output sa_tap_t       tap_o
);
  localparam logic [PW-1:0] FIRST_P = PW'(BASE);
  localparam logic [PW-1:0] LAST_P  = PW'(BASE + N_SA - 1);
  localparam logic [FW-1:0] FRM_MAX = FW'(NFRM - 1);

  logic odd_frame;
  logic in_window;

  assign odd_frame = frm_i[0] && (frm_i <= FRM_MAX);
  assign in_window = (pos_i >= FIRST_P) && (pos_i <= LAST_P);

  always_comb begin
    tap_o = '0;
    if (vld_i && odd_frame && in_window) begin
      tap_o.hit  = 1'b1;
      tap_o.idx  = IDX_W'(pos_i - FIRST_P);
      tap_o.last = (pos_i == LAST_P);
    end
  end
endmodule

// File: rtl/e1_sa_stage_bank.sv
module e1_sa_stage_bank
  import e1_sa_pkg::*;
#(
  parameter int N_SA = SA_NUM,
  parameter int DW   = SA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               bit_i,
  input  logic               xfer_i,
  output logic [N_SA*DW-1:0] live_o
);
  logic [N_SA*DW-1:0] live_q;

  for (genvar k = 0; k < N_SA; k++) begin : g_lane
    logic [DW-1:0] stage_q;
    logic          sel;

    assign sel = hit_i && (idx_i == IDX_W'(k));

    always_ff @(posedge clk_i) begin
      if (!rst_ni)  stage_q <= '0;
      else if (sel) stage_q <= {stage_q[DW-2:0], bit_i};
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni)     live_q[k*DW +: DW] <= '0;
      else if (xfer_i) live_q[k*DW +: DW] <= stage_q;
    end
  end

  assign live_o = live_q;

  // R3
  live_group_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(live_q) |-> $past(xfer_i));
endmodule

// File: rtl/e1_sa_mf_ctrl.sv
module e1_sa_mf_ctrl
  import e1_sa_pkg::*;
#(
  parameter int ODD = ODD_PER_MF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mf_start_i,
  input  logic last_i,
  output logic xfer_o,
  output logic irq_o
);
  localparam int CNT_W = $clog2(ODD + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ODD);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(ODD + 1);

  logic [CNT_W-1:0] odd_cnt_q;
  logic             armed_q;
  logic             irq_q;

  assign xfer_o = mf_start_i && armed_q && (odd_cnt_q == FULL);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      odd_cnt_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= xfer_o;
      if (mf_start_i) begin
        armed_q   <= 1'b1;
        odd_cnt_q <= '0;
      end else if (armed_q && last_i && odd_cnt_q != SAT) begin
        odd_cnt_q <= odd_cnt_q + 1'b1;
      end
    end
  end

  assign irq_o = irq_q;

  // R5
  irq_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(mf_start_i));

  // R7
  irq_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(armed_q));
endmodule

// File: rtl/e1_sa_read_mux.sv
module e1_sa_read_mux
  import e1_sa_pkg::*;
#(
  parameter int N_SA = SA_NUM,
  parameter int DW   = SA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   addr_i,
  input  logic [N_SA*DW-1:0] regs_i,
  output logic [DW-1:0]      data_o
);
  localparam logic [IDX_W-1:0] TOP_ADDR = IDX_W'(N_SA - 1);

  always_comb begin
    data_o = '0;
    for (int k = 0; k < N_SA; k++) begin
      if (addr_i == IDX_W'(k)) data_o = regs_i[k*DW +: DW];
    end
  end

  // R8
  rd_hole_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > TOP_ADDR) |-> (data_o == '0));
endmodule

// File: rtl/e1_sa_capture.sv
module e1_sa_capture
  import e1_sa_pkg::*;
#(
  parameter int N_SA = SA_NUM,
  parameter int DW   = SA_W,
  parameter int BASE = SA_FIRST,
  parameter int ODD  = ODD_PER_MF,
  parameter int NFRM = FRAMES_PER_MF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_vld_i,
  input  logic               rx_bit_i,
  input  logic [POS_W-1:0]   bit_pos_i,
  input  logic [FRM_W-1:0]   frm_num_i,
  input  logic               mf_start_i,
  input  logic [IDX_W-1:0]   rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [N_SA*DW-1:0] sa_regs_o,
  output logic               mf_irq_o
);
  sa_tap_t tap;
  logic    xfer;

  e1_sa_slot_decode #(
    .N_SA(N_SA), .BASE(BASE), .PW(POS_W), .FW(FRM_W), .NFRM(NFRM)
  ) u_decode (
    .vld_i(rx_vld_i),
    .pos_i(bit_pos_i),
    .frm_i(frm_num_i),
    .tap_o(tap)
  );

  e1_sa_stage_bank #(.N_SA(N_SA), .DW(DW)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (tap.hit),
    .idx_i (tap.idx),
    .bit_i (rx_bit_i),
    .xfer_i(xfer),
    .live_o(sa_regs_o)
  );

  e1_sa_mf_ctrl #(.ODD(ODD)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mf_start_i(mf_start_i),
    .last_i    (tap.last),
    .xfer_o    (xfer),
    .irq_o     (mf_irq_o)
  );

  e1_sa_read_mux #(.N_SA(N_SA), .DW(DW)) u_rd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(rd_addr_i),
    .regs_i(sa_regs_o),
    .data_o(rd_data_o)
  );

  // R5
  irq_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_irq_o |=> !mf_irq_o);

  // R4
  regs_only_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sa_regs_o) |-> mf_irq_o);
endmodule

// File: tb/e1_sa_capture_bench.sv
`timescale 1ns/1ps
module e1_sa_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld, dbit, mfs;
  logic [7:0]  pos;
  logic [3:0]  frm;
  logic [2:0]  raddr;
  logic [7:0]  rdata;
  logic [39:0] regs;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  e1_sa_capture u_e1_sa_capture (
    .clk_i(clk), .rst_ni(rst_n), .rx_vld_i(vld), .rx_bit_i(dbit),
    .bit_pos_i(pos), .frm_num_i(frm), .mf_start_i(mfs),
    .rd_addr_i(raddr), .rd_data_o(rdata), .sa_regs_o(regs), .mf_irq_o(irq)
  );

  localparam logic [39:0] VEC [6] = '{
    40'h0000000000,
    40'hFFFFFFFFFF,
    40'h8001A55A3C,
    40'h0102040810,
    40'hC3E7182400,
    40'h7E5AF00F99
  };

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sends one multiframe of nf frames. Reports what the outputs showed
  // right after its start strobe, one cycle later, and in frame 8.
  task automatic send_mf(input logic [39:0] pat, input int nf,
                         output logic irq0, output logic [39:0] regs0,
                         output logic irq1, output logic [39:0] mid);
    for (int f = 0; f < nf; f++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        if (f == 0 && b == 1) begin irq0 = irq; regs0 = regs; end
        if (f == 0 && b == 2) irq1 = irq;
        if (f == 8 && b == 0) mid = regs;
        vld = 1'b1;
        pos = 8'(b);
        frm = 4'(f);
        mfs = (f == 0 && b == 0);
        if (b >= 3 && b <= 7) begin
          if (f % 2 == 1) dbit = pat[(b-3)*8 + 7 - (f-1)/2];
          else            dbit = ~pat[(b-3)*8 + 7 - f/2];
        end else begin
          dbit = 1'(b ^ f);
        end
        if (f % 2 == 1 && b >= 3 && b <= 7) begin
          // R9: invalid cycle with inverted data at the same Sa slot
          @(negedge clk);
          vld  = 1'b0;
          mfs  = 1'b0;
          dbit = ~dbit;
        end
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic        i0, i1;
    logic [39:0] r0, md;
    rst_n = 1'b0; vld = 1'b0; dbit = 1'b0; mfs = 1'b0;
    pos = '0; frm = '0; raddr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset regs", regs, 40'h0);
    chk("R7 reset irq", {39'h0, irq}, 40'h0);
    chk("R7 reset rd_data", {32'h0, rdata}, 40'h0);

    // Walk the vector table; each multiframe's bits appear at the next strobe.
    send_mf(VEC[0], 16, i0, r0, i1, md);
    chk("R7 first strobe no irq", {39'h0, i0}, 40'h0);
    chk("R7 first strobe regs", r0, 40'h0);
    for (int i = 1; i < 6; i++) begin
      send_mf(VEC[i], 16, i0, r0, i1, md);
      chk("R5 irq at boundary", {39'h0, i0}, 40'h1);
      chk("R1 R2 R3 R9 regs after refresh", r0, VEC[i-1]);
      chk("R5 irq one cycle", {39'h0, i1}, 40'h0);
      chk("R4 regs stable mid multiframe", md, VEC[i-1]);
    end

    // R8 read port over all addresses
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      raddr = 3'(a);
      #1;
      chk("R8 read port", {32'h0, rdata}, (a < 5) ? {32'h0, VEC[4][a*8 +: 8]} : 40'h0);
    end

    // R6 short multiframe (10 frames, 5 odd) must be discarded
    send_mf(40'hDEADBEEF12, 10, i0, r0, i1, md);
    chk("R6 refresh before short mf", r0, VEC[5]);
    send_mf(40'h1122334455, 16, i0, r0, i1, md);
    chk("R6 short mf no irq", {39'h0, i0}, 40'h0);
    chk("R6 short mf regs kept", r0, VEC[5]);
    send_mf(40'h0, 16, i0, r0, i1, md);
    chk("R6 recovery irq", {39'h0, i0}, 40'h1);
    chk("R6 recovery regs", r0, 40'h1122334455);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule